// File: doc/BRIEF.md
# Joystick Axis Timing Converter

This block measures up to four analog joystick axes by timing. Each axis has a one-bit comparator input that goes high when a measurement is started and falls back after a time that depends on the stick position. After a start, the block counts prescaled clock ticks for every enabled axis while its comparator input stays high. It freezes each count when its input falls, and it reports completion through a ready flag and an optional interrupt pulse.

Software drives the block through a small byte-addressed register window. A write to the legacy offset or to the result offset starts a measurement. The axis configuration register holds the per-axis enables, the read-back selector, the continuous mode bit and the read-only ready flag. The hardware configuration register holds the interrupt enable, the tick-rate selector and the legacy window enable, which leaves the block as a plain output. In continuous mode the block starts a new measurement on its own after each completion, so the result words track the stick and an interrupt arrives with every pass.

Top module: `joy_axis_ctrl`

## Requirements
- R1: After reset, offsets 1, 2 and 4 read 0x0000, irq is low and legacy_en is low.
- R2: Offset 1 holds the axis enables in bits 3:0 (bit i = axis i), the read selector in bits 5:4 (value k selects axis k), continuous mode in bit 6 and the ready flag in bit 7; a write to bit 7 has no effect on it.
- R3: Offset 4 holds the interrupt enable in bit 0, the tick rate in bits 2:1 (0 = every cycle, 1 = every 2nd, 2 = every 20th, 3 = every 200th cycle) and the legacy window enable in bit 3, which drives legacy_en; bits 15:4 always read as zero.
- R4: A write of any value to offset 0 or offset 2 starts a measurement: ready clears on that edge and the counters of the axes enabled at that moment restart from zero.
- R5: After a start, an enabled axis counts one per tick while its comparator input is high and freezes on the first edge at which the input is low; with the input high on N edges after the start edge, the result is floor(N / rate divisor).
- R6: A count stops at 0xFFFF and does not wrap.
- R7: Once every axis enabled at the start has frozen, ready sets, the counts of those axes are copied into their result words, and a read of offset 2 returns the result word of the selected axis.
- R8: At each completion, irq pulses high for one cycle if the interrupt enable is set and at least one axis was enabled; with no axis enabled, ready still sets but irq stays low.
- R9: An axis that is not enabled at the start is not counted, and its result word keeps its previous value.
- R10: With continuous mode off, the result words and the ready flag stay unchanged after completion until the next start, whatever the comparator inputs do.
- R11: With continuous mode on, each completion starts the next measurement, which yields a fresh irq pulse per completion; once the mode is turned off, the pulses stop after the pass in progress.
- R12: A start write on the same edge as a completion takes priority: that completion raises no irq and leaves ready clear, and only the new measurement completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| axis_cmp | input | 4 | Comparator inputs, bit i for axis i |
| irq | output | 1 | One-cycle measurement-ready interrupt pulse |
| legacy_en | output | 1 | Legacy address window enable |

## Verification
Two events can land on the same clock edge: the completion of a measurement and a new start write. The bench provokes this with a single enabled axis whose comparator stays low, so completion falls exactly two edges after a start, and it places the second start write on that edge. It then requires that ready reads clear right after the collision and that only one irq pulse appears in total, from the second measurement. The continuous-mode test stresses the same path from the other side, because there the block restarts itself on every completion.

// File: rtl/joy_pkg.sv
// Shared types and register offsets for the joystick axis timing converter.
package joy_pkg;

    localparam int JOY_AXES = 4;

    localparam logic [2:0] OFS_LEGACY = 3'd0;
    localparam logic [2:0] OFS_AXCFG  = 3'd1;
    localparam logic [2:0] OFS_RESULT = 3'd2;
    localparam logic [2:0] OFS_HWCFG  = 3'd4;

    typedef enum logic [1:0] {
        RATE_FULL  = 2'd0,
        RATE_DIV_B = 2'd1,
        RATE_DIV_C = 2'd2,
        RATE_DIV_D = 2'd3
    } rate_e;

    typedef struct packed {
        logic                cont;
        logic [1:0]          sel;
        logic [JOY_AXES-1:0] en;
    } axcfg_t;

    typedef struct packed {
        logic  legacy;
        rate_e rate;
        logic  irq_en;
    } hwcfg_t;

endpackage

// File: rtl/joy_prescaler.sv
// Tick generator for the axis counters.
// Emits tick once every 1, DIV_B, DIV_C or DIV_D cycles, chosen by rate.
// Assumes clr restarts the phase so the first tick comes a full period
// after a measurement start.
module joy_prescaler
    import joy_pkg::*;
#(
    parameter int DIV_B = 2,
    parameter int DIV_C = 20,
    parameter int DIV_D = 200
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  rate_e rate,
    output logic  tick
);
    localparam int PW = (DIV_D > 2) ? $clog2(DIV_D) : 1;

    logic [PW-1:0] phase_q;
    logic [PW-1:0] limit;

    // Terminal phase value for the selected rate.
    always_comb begin
        case (rate)
            RATE_DIV_B: limit = PW'(DIV_B - 1);
            RATE_DIV_C: limit = PW'(DIV_C - 1);
            RATE_DIV_D: limit = PW'(DIV_D - 1);
            default:    limit = '0;
        endcase
    end

    assign tick = (phase_q >= limit);

    // Phase counter, wraps on tick, restarted by clr.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || tick) phase_q <= '0;
        else                       phase_q <= phase_q + 1'b1;
    end
endmodule

// File: rtl/joy_axis_counter.sv
// One axis timer. On start it restarts from zero when the axis is enabled,
// then counts ticks while cmp is high and freezes when cmp falls.
// Assumes start and tick are single-cycle qualifiers from the parent.
module joy_axis_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             enable,
    input  logic             tick,
    input  logic             cmp,
    output logic [CNT_W-1:0] count,
    output logic             busy
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count while busy and cmp high, saturate at CNT_MAX, stop on cmp low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            busy  <= 1'b0;
        end else if (start) begin
            busy <= enable;
            if (enable) count <= '0;
        end else if (busy) begin
            if (!cmp)                        busy  <= 1'b0;
            else if (tick && count != CNT_MAX) count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/joy_axis_ctrl.sv
// Joystick axis timing converter top.
// Holds the two configuration registers, starts measurements on writes to
// the legacy or result offsets, latches results on completion, raises the
// ready flag and interrupt, and serves reads through a combinational mux.
// Assumes bus_wr is a one-cycle strobe per access.
module joy_axis_ctrl
    import joy_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_B = 2,
    parameter int DIV_C = 20,
    parameter int DIV_D = 200
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          bus_addr,
    input  logic                bus_wr,
    input  logic [7:0]          bus_wdata,
    output logic [15:0]         bus_rdata,
    input  logic [JOY_AXES-1:0] axis_cmp,
    output logic                irq,
    output logic                legacy_en
);
    localparam int RD_PAD = 16 - CNT_W;

    axcfg_t              axcfg_q;
    hwcfg_t              hwcfg_q;
    logic                measuring_q;
    logic                ready_q;
    logic                irq_q;
    logic [JOY_AXES-1:0] run_en_q;
    logic [CNT_W-1:0]    result_q [JOY_AXES];
    logic [CNT_W-1:0]    count    [JOY_AXES];
    logic [JOY_AXES-1:0] busy;
    logic                tick;
    logic                trigger;
    logic                done;
    logic                start;

    assign trigger   = bus_wr && (bus_addr == OFS_LEGACY || bus_addr == OFS_RESULT);
    assign done      = measuring_q && (busy == '0);
    assign start     = trigger || (done && axcfg_q.cont);
    assign irq       = irq_q;
    assign legacy_en = hwcfg_q.legacy;

    joy_prescaler #(
        .DIV_B (DIV_B),
        .DIV_C (DIV_C),
        .DIV_D (DIV_D)
    ) presc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .rate  (hwcfg_q.rate),
        .tick  (tick)
    );

    for (genvar a = 0; a < JOY_AXES; a++) begin : g_axis
        joy_axis_counter #(.CNT_W(CNT_W)) cnt_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .start  (start),
            .enable (axcfg_q.en[a]),
            .tick   (tick),
            .cmp    (axis_cmp[a]),
            .count  (count[a]),
            .busy   (busy[a])
        );
    end

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            axcfg_q <= '0;
            hwcfg_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == OFS_AXCFG) axcfg_q <= axcfg_t'(bus_wdata[6:0]);
            if (bus_addr == OFS_HWCFG) hwcfg_q <= hwcfg_t'(bus_wdata[3:0]);
        end
    end

    // Measurement sequencing: start wins over a same-edge completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            measuring_q <= 1'b0;
            ready_q     <= 1'b0;
            irq_q       <= 1'b0;
            run_en_q    <= '0;
        end else begin
            irq_q <= 1'b0;
            if (trigger) begin
                measuring_q <= 1'b1;
                ready_q     <= 1'b0;
                run_en_q    <= axcfg_q.en;
            end else if (done) begin
                ready_q     <= 1'b1;
                irq_q       <= hwcfg_q.irq_en && (run_en_q != '0);
                measuring_q <= axcfg_q.cont;
                if (axcfg_q.cont) run_en_q <= axcfg_q.en;
            end
        end
    end

    // Result latches for the axes that took part in the finished pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < JOY_AXES; a++) result_q[a] <= '0;
        end else if (done && !trigger) begin
            for (int a = 0; a < JOY_AXES; a++)
                if (run_en_q[a]) result_q[a] <= count[a];
        end
    end

    // Read mux.
    always_comb begin
        case (bus_addr)
            OFS_AXCFG:  bus_rdata = {8'h00, ready_q, axcfg_q};
            OFS_RESULT: bus_rdata = {{RD_PAD{1'b0}}, result_q[axcfg_q.sel]};
            OFS_HWCFG:  bus_rdata = {12'h000, hwcfg_q};
            default:    bus_rdata = 16'h0000;
        endcase
    end
endmodule

// File: rtl/joy_axis_ctrl_chk.sv
// Property checker for joy_axis_ctrl, attached by bind below.
// Observes bus ports and the sequencing state of the top module.
module joy_axis_ctrl_chk #(
    parameter int RW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    bus_addr,
    input logic          bus_wr,
    input logic [15:0]   bus_rdata,
    input logic          irq,
    input logic          ready,
    input logic          measuring,
    input logic          cont,
    input logic          irq_en_past,
    input logic [3:0]    run_en,
    input logic [RW-1:0] results
);
    logic start_wr;
    assign start_wr = bus_wr && (bus_addr == 3'd0 || bus_addr == 3'd2);

    AST_START_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> (!ready && !irq)) else $error("start did not clear ready"); // R4

    AST_IRQ_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ready && run_en != 4'h0)) else $error("irq without ready"); // R8

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(irq_en_past)) else $error("irq while disabled"); // R8

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !cont) |=> !irq) else $error("irq longer than one cycle"); // R8

    AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !measuring && !start_wr) |=> ($stable(results) && ready)) else $error("results moved"); // R10

    AST_HWCFG_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 3'd4) |-> (bus_rdata[15:4] == 12'h000)) else $error("hwcfg upper bits"); // R3
endmodule

bind joy_axis_ctrl joy_axis_ctrl_chk #(.RW(4 * CNT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rdata   (bus_rdata),
    .irq         (irq),
    .ready       (ready_q),
    .measuring   (measuring_q),
    .cont        (axcfg_q.cont),
    .irq_en_past (hwcfg_q.irq_en),
    .run_en      (run_en_q),
    .results     ({result_q[3], result_q[2], result_q[1], result_q[0]})
);

// File: tb/joy_axis_ctrl_tb_top.sv
`timescale 1ns/1ps
module joy_axis_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [15:0] bus_rdata;
    logic [3:0]  axis_cmp = 4'h0;
    logic        irq;
    logic        legacy_en;

    int total = 0;
    int bad = 0;
    int irq_cnt = 0;

    always #2 clk = ~clk;

    joy_axis_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .axis_cmp  (axis_cmp),
        .irq       (irq),
        .legacy_en (legacy_en)
    );

    always @(negedge clk) if (irq) irq_cnt++;

    typedef struct packed {
        logic [1:0]  rate;
        logic [3:0]  en;
        logic [1:0]  sel;
        logic [15:0] n;
        logic [15:0] expv;
    } vec_t;

    // rate, enables, selector, high edges, expected floor(n/div)
    localparam vec_t VECS [5] = '{
        '{2'd0, 4'hF, 2'd1, 16'd0,   16'd0},
        '{2'd0, 4'h1, 2'd0, 16'd10,  16'd10},
        '{2'd1, 4'h3, 2'd1, 16'd11,  16'd5},
        '{2'd2, 4'h4, 2'd2, 16'd45,  16'd2},
        '{2'd3, 4'h8, 2'd3, 16'd450, 16'd2}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #800000;
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        int i0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(3'd1, v); check("R1 axcfg", v, 16'h0000);
        rd(3'd2, v); check("R1 result", v, 16'h0000);
        rd(3'd4, v); check("R1 hwcfg", v, 16'h0000);
        check("R1 irq", {15'h0, irq}, 16'h0000);
        check("R1 legacy_en", {15'h0, legacy_en}, 16'h0000);

        // R2 ready bit not writable; R3 upper bits read zero, legacy output
        wr(3'd1, 8'hFF); rd(3'd1, v); check("R2 axcfg write", v, 16'h007F);
        wr(3'd4, 8'hFF); rd(3'd4, v); check("R3 hwcfg write", v, 16'h000F);
        check("R3 legacy_en", {15'h0, legacy_en}, 16'h0001);

        // R5 R7 R8 table of measurements
        for (int k = 0; k < 5; k++) begin
            wr(3'd4, {5'b0, VECS[k].rate, 1'b1});
            wr(3'd1, {2'b00, VECS[k].sel, VECS[k].en});
            axis_cmp = VECS[k].en;
            i0 = irq_cnt;
            wr((k % 2 == 0) ? 3'd0 : 3'd2, 8'hA5);
            repeat (int'(VECS[k].n)) @(posedge clk);
            #1 axis_cmp = 4'h0;
            repeat (4) @(posedge clk);
            rd(3'd2, v); check("R5 R7 result", v, VECS[k].expv);
            rd(3'd1, v); check("R7 ready", {15'h0, v[7]}, 16'h0001);
            check("R8 irq pulses", 16'(irq_cnt - i0), 16'd1);
        end

        // R9 disabled axis keeps its result while its input toggles high
        wr(3'd4, 8'h01);
        wr(3'd1, 8'h01);
        axis_cmp = 4'hF;
        wr(3'd0, 8'h00);
        repeat (7) @(posedge clk);
        #1 axis_cmp = 4'h0;
        repeat (4) @(posedge clk);
        rd(3'd2, v); check("R9 enabled axis", v, 16'd7);
        wr(3'd1, 8'h10);
        rd(3'd2, v); check("R9 disabled axis held", v, 16'd5);

        // R10 results and ready stay put after completion
        wr(3'd1, 8'h00);
        axis_cmp = 4'hF;
        repeat (30) @(posedge clk);
        #1 axis_cmp = 4'h0;
        rd(3'd2, v); check("R10 result held", v, 16'd7);
        rd(3'd1, v); check("R10 ready held", {15'h0, v[7]}, 16'h0001);

        // R4 start clears ready
        wr(3'd1, 8'h01);
        axis_cmp = 4'h1;
        wr(3'd2, 8'h3C);
        rd(3'd1, v); check("R4 ready cleared", {15'h0, v[7]}, 16'h0000);
        #1 axis_cmp = 4'h0;
        repeat (4) @(posedge clk);

        // R8 no irq with no axis enabled, ready still sets
        wr(3'd1, 8'h00);
        i0 = irq_cnt;
        wr(3'd0, 8'h00);
        repeat (4) @(posedge clk);
        rd(3'd1, v); check("R8 ready no axes", {15'h0, v[7]}, 16'h0001);
        check("R8 no irq no axes", 16'(irq_cnt - i0), 16'd0);

        // R12 start on the completion edge wins
        wr(3'd1, 8'h01);
        i0 = irq_cnt;
        wr(3'd0, 8'h00);
        @(posedge clk);
        wr(3'd0, 8'h00);
        rd(3'd1, v); check("R12 ready clear on collision", {15'h0, v[7]}, 16'h0000);
        repeat (5) @(posedge clk);
        check("R12 single irq", 16'(irq_cnt - i0), 16'd1);
        rd(3'd1, v); check("R12 ready after", {15'h0, v[7]}, 16'h0001);

        // R11 continuous mode repeats interrupts, then stops
        wr(3'd1, 8'h41);
        i0 = irq_cnt;
        wr(3'd0, 8'h00);
        repeat (20) @(posedge clk);
        total++;
        if (irq_cnt - i0 < 3) begin
            bad++;
            $display("FAIL R11 repeat irq actual=%0d expected>=3", irq_cnt - i0);
        end
        wr(3'd1, 8'h01);
        repeat (6) @(posedge clk);
        i0 = irq_cnt;
        repeat (10) @(posedge clk);
        check("R11 irq stopped", 16'(irq_cnt - i0), 16'd0);

        // R6 saturation at 0xFFFF
        wr(3'd4, 8'h00);
        wr(3'd1, 8'h01);
        axis_cmp = 4'h1;
        wr(3'd0, 8'h00);
        repeat (70000) @(posedge clk);
        #1 axis_cmp = 4'h0;
        repeat (4) @(posedge clk);
        rd(3'd2, v); check("R6 saturate", v, 16'hFFFF);

        finish_run();
    end
endmodule